// File: doc/BRIEF.md
# Cascaded Four-Lane Reconfigurable ALU Pipeline

This block is the execute stage of a reconfigurable vector coprocessor. Four 32-bit processing lanes form a chain. On every issued cycle each lane picks two operands from four sources: its own registered result, the registered result of the lane before it, one word read from a shared 16-entry register file, or zero. It then registers the result of one ALU operation on them. A lane's result is visible to the next lane one cycle later, so a chain of operations flows down the lanes with no extra staging.

Each lane keeps four stored contexts. A context names an operation and the two operand sources. The caller gives a context index for every lane in every cycle, so a lane can change its function from one cycle to the next. A configuration port rewrites one context of one lane while the lanes keep running. A write that aims at the slot a lane is using in that same issued cycle is refused and flagged.

The register file is read combinationally into the lanes at the rising edge and written on the falling edge. A result written back in the first half of a cycle can therefore be consumed at the rising edge that closes that cycle. Write-back can take the result of any lane. A separate load port places data words into the file.

Top module: `cascade_alu_pipe`

## Requirements
- R1: Synchronous reset clears every lane result to zero, clears the register file, drops `cfg_err`, and sets every context of every lane to opcode pass with operand A from the register file and operand B zero.
- R2: Opcode encoding: 0 add, 1 subtract (A-B), 2 and, 3 or, 4 xor, 5 shift left A by B[4:0], 6 logical shift right A by B[4:0], 7 rotate left A by B[4:0], 8 pass A. Any other code yields zero.
- R3: Operand source encoding: 0 the lane's own result, 1 the previous lane's result, 2 the lane's register-file read, 3 zero. For lane 0 the previous-lane source reads as zero.
- R4: A lane's previous-lane operand is the value that lane held before the clock edge, so a result reaches the next lane exactly one cycle after it is produced.
- R5: When `issue_valid` is high, each lane executes the context chosen by its 2-bit field of `ctx_sel` (lane n at bits 2n+1:2n) and reads register `rf_raddr[4n+3:4n]`. When `issue_valid` is low, all lane results hold.
- R6: A configuration write (`cfg_we`) to a slot that is not in use stores the new context, and a later issue of that slot uses it. The slot is not in use if it differs from the lane's `ctx_sel` field, or if `issue_valid` is low.
- R7: A configuration write to the slot that the target lane executes in the same issued cycle is discarded. `cfg_err` is high in the following cycle only, and the lane's old context stays in effect.
- R8: A register written back during a cycle is read with its new value by any lane issued at the rising edge that ends that cycle.
- R9: Write-back stores the current result of the lane chosen by `wb_lane` into register `wb_addr`. When write-back and the load port target the same register in the same cycle, the write-back value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register file written on falling edge |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Execute one step on all lanes |
| ctx_sel | input | 8 | Active context index per lane, 2 bits each |
| rf_raddr | input | 16 | Register-file read address per lane, 4 bits each |
| wb_en | input | 1 | Write back a lane result this cycle |
| wb_lane | input | 2 | Lane whose result is written back |
| wb_addr | input | 4 | Destination register of write-back |
| ld_en | input | 1 | Load a data word into the register file |
| ld_addr | input | 4 | Destination register of the load |
| ld_data | input | 32 | Word to load |
| cfg_we | input | 1 | Context write strobe |
| cfg_lane | input | 2 | Lane whose context is written |
| cfg_slot | input | 2 | Context slot written |
| cfg_op | input | 4 | Opcode field of the new context |
| cfg_src_a | input | 2 | Operand A source of the new context |
| cfg_src_b | input | 2 | Operand B source of the new context |
| cfg_err | output | 1 | Previous cycle's context write was refused |
| lane_res | output | 128 | Registered lane results, lane n at bits 32n+31:32n |

## Verification
The case that needs the most care is a configuration write that meets an issued cycle on the same lane. The bench drives both in one cycle, once where the written slot equals the lane's selected slot, and once where the lane runs a different slot or nothing is issued. It judges the outcome at the ports: the flag in the next cycle, then a later issue of the written slot that shows whether the old or the new context is in effect. A second collision is a write-back and a register read in the same cycle. A lane issued at the closing edge must see the written-back word, and this is checked on that lane's result.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int DW  = 32;
    localparam int SHW = $clog2(DW);

    typedef logic [DW-1:0] word_t;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SHL  = 4'd5,
        OP_SHR  = 4'd6,
        OP_ROL  = 4'd7,
        OP_PASS = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        SRC_SELF = 2'd0,
        SRC_PREV = 2'd1,
        SRC_REG  = 2'd2,
        SRC_ZERO = 2'd3
    } src_e;

    typedef struct packed {
        op_e  op;
        src_e sa;
        src_e sb;
    } ctx_t;

    localparam ctx_t CTX_RESET = '{op: OP_PASS, sa: SRC_REG, sb: SRC_ZERO};

    function automatic word_t pick(src_e s, word_t self_v, word_t prev_v, word_t reg_v);
        case (s)
            SRC_SELF: return self_v;
            SRC_PREV: return prev_v;
            SRC_REG:  return reg_v;
            default:  return '0;
        endcase
    endfunction

    function automatic word_t alu(op_e op, word_t a, word_t b);
        logic [SHW-1:0] sh;
        logic [SHW:0]   rsh;
        sh  = b[SHW-1:0];
        rsh = (SHW+1)'(DW) - {1'b0, sh};
        case (op)
            OP_ADD:  return a + b;
            OP_SUB:  return a - b;
            OP_AND:  return a & b;
            OP_OR:   return a | b;
            OP_XOR:  return a ^ b;
            OP_SHL:  return a << sh;
            OP_SHR:  return a >> sh;
            OP_ROL:  return (a << sh) | (a >> rsh);
            OP_PASS: return a;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/cap_ctx_bank.sv
module cap_ctx_bank
    import cap_pkg::*;
#(
    parameter int CTXS = 4,
    localparam int CW  = $clog2(CTXS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_slot,
    input  ctx_t          wr_ctx,
    input  logic [CW-1:0] rd_slot,
    output ctx_t          rd_ctx
);

    ctx_t slots [CTXS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CTXS; i++) slots[i] <= CTX_RESET;
        end else if (wr_en) begin
            slots[wr_slot] <= wr_ctx;
        end
    end

    assign rd_ctx = slots[rd_slot];

endmodule

// File: rtl/cap_lane.sv
module cap_lane
    import cap_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  ctx_t  ctx,
    input  word_t prev_v,
    input  word_t reg_v,
    output word_t res
);

    word_t opa;
    word_t opb;

    always_comb begin
        opa = pick(ctx.sa, res, prev_v, reg_v);
        opb = pick(ctx.sb, res, prev_v, reg_v);
    end

    always_ff @(posedge clk) begin
        if (rst)     res <= '0;
        else if (en) res <= alu(ctx.op, opa, opb);
    end

endmodule

// File: rtl/cap_regfile.sv
module cap_regfile
    import cap_pkg::*;
#(
    parameter int REGS = 16,
    parameter int RDP  = 4,
    localparam int AW  = $clog2(REGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RDP*AW-1:0] rd_addr,
    output logic [RDP*DW-1:0] rd_data,
    input  logic              wb_en,
    input  logic [AW-1:0]     wb_addr,
    input  word_t             wb_data,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  word_t             ld_data
);

    word_t mem [REGS];

    // Falling-edge write; the later statement gives write-back priority.
    always_ff @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < REGS; i++) mem[i] <= '0;
        end else begin
            if (ld_en) mem[ld_addr] <= ld_data;
            if (wb_en) mem[wb_addr] <= wb_data;
        end
    end

    for (genvar p = 0; p < RDP; p++) begin : g_rd
        assign rd_data[p*DW +: DW] = mem[rd_addr[p*AW +: AW]];
    end

endmodule

// File: rtl/cascade_alu_pipe.sv
module cascade_alu_pipe
    import cap_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CTXS  = 4,
    parameter int REGS  = 16,
    localparam int CW   = $clog2(CTXS),
    localparam int AW   = $clog2(REGS),
    localparam int LW   = $clog2(LANES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue_valid,
    input  logic [LANES*CW-1:0] ctx_sel,
    input  logic [LANES*AW-1:0] rf_raddr,
    input  logic                wb_en,
    input  logic [LW-1:0]       wb_lane,
    input  logic [AW-1:0]       wb_addr,
    input  logic                ld_en,
    input  logic [AW-1:0]       ld_addr,
    input  logic [DW-1:0]       ld_data,
    input  logic                cfg_we,
    input  logic [LW-1:0]       cfg_lane,
    input  logic [CW-1:0]       cfg_slot,
    input  logic [3:0]          cfg_op,
    input  logic [1:0]          cfg_src_a,
    input  logic [1:0]          cfg_src_b,
    output logic                cfg_err,
    output logic [LANES*DW-1:0] lane_res
);

    logic [CW-1:0]     sel_arr [LANES];
    word_t             res_arr [LANES];
    ctx_t              act_ctx [LANES];
    logic [LANES*DW-1:0] rf_rd;
    ctx_t              new_ctx;
    logic              clash;
    logic              cfg_ok;

    for (genvar l = 0; l < LANES; l++) begin : g_unpack
        assign sel_arr[l]             = ctx_sel[l*CW +: CW];
        assign lane_res[l*DW +: DW]   = res_arr[l];
    end

    assign new_ctx = '{op: op_e'(cfg_op), sa: src_e'(cfg_src_a), sb: src_e'(cfg_src_b)};
    assign clash   = issue_valid && (cfg_slot == sel_arr[cfg_lane]);
    assign cfg_ok  = cfg_we && !clash;

    always_ff @(posedge clk) begin
        if (rst) cfg_err <= 1'b0;
        else     cfg_err <= cfg_we && clash;
    end

    cap_regfile #(.REGS(REGS), .RDP(LANES)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (rf_raddr),
        .rd_data (rf_rd),
        .wb_en   (wb_en),
        .wb_addr (wb_addr),
        .wb_data (res_arr[wb_lane]),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        word_t prev_v;
        if (l == 0) begin : g_head
            assign prev_v = '0;
        end else begin : g_link
            assign prev_v = res_arr[l-1];
        end

        cap_ctx_bank #(.CTXS(CTXS)) u_ctx (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (cfg_ok && (cfg_lane == LW'(l))),
            .wr_slot (cfg_slot),
            .wr_ctx  (new_ctx),
            .rd_slot (sel_arr[l]),
            .rd_ctx  (act_ctx[l])
        );

        cap_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .en     (issue_valid),
            .ctx    (act_ctx[l]),
            .prev_v (prev_v),
            .reg_v  (rf_rd[l*DW +: DW]),
            .res    (res_arr[l])
        );
    end

endmodule

// File: rtl/cap_checker.sv
module cap_checker
    import cap_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CTXS  = 4,
    localparam int CW   = $clog2(CTXS),
    localparam int LW   = $clog2(LANES)
) (
    input logic                clk,
    input logic                rst,
    input logic                issue_valid,
    input logic [LANES*CW-1:0] ctx_sel,
    input logic                cfg_we,
    input logic [LW-1:0]       cfg_lane,
    input logic [CW-1:0]       cfg_slot,
    input logic                cfg_err,
    input logic [LANES*DW-1:0] lane_res,
    input ctx_t                act_ctx [LANES]
);

    word_t lr [LANES];
    logic  hit;

    for (genvar l = 0; l < LANES; l++) begin : g_sl
        assign lr[l] = lane_res[l*DW +: DW];
    end

    assign hit = cfg_we && issue_valid && (ctx_sel[cfg_lane*CW +: CW] == cfg_slot);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (lane_res == '0 && !cfg_err));                                  // R1

    AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (rst)
        hit |=> cfg_err);                                                       // R7

    AST_NO_FALSE_FLAG: assert property (@(posedge clk) disable iff (rst)
        !hit |=> !cfg_err);                                                     // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !issue_valid |=> $stable(lane_res));                                    // R5

    AST_CHAIN_NEXT: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && act_ctx[1].op == OP_PASS && act_ctx[1].sa == SRC_PREV)
        |=> lr[1] == $past(lr[0]));                                             // R4

    AST_HEAD_PREV_ZERO: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && act_ctx[0].op == OP_PASS && act_ctx[0].sa == SRC_PREV)
        |=> lr[0] == '0);                                                       // R3

endmodule

bind cascade_alu_pipe cap_checker #(.LANES(LANES), .CTXS(CTXS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .issue_valid (issue_valid),
    .ctx_sel     (ctx_sel),
    .cfg_we      (cfg_we),
    .cfg_lane    (cfg_lane),
    .cfg_slot    (cfg_slot),
    .cfg_err     (cfg_err),
    .lane_res    (lane_res),
    .act_ctx     (act_ctx)
);

// File: tb/cascade_alu_pipe_test.sv
module cascade_alu_pipe_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         issue_valid = 1'b0;
    logic [7:0]   ctx_sel = '0;
    logic [15:0]  rf_raddr = '0;
    logic         wb_en = 1'b0;
    logic [1:0]   wb_lane = '0;
    logic [3:0]   wb_addr = '0;
    logic         ld_en = 1'b0;
    logic [3:0]   ld_addr = '0;
    logic [31:0]  ld_data = '0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_lane = '0;
    logic [1:0]   cfg_slot = '0;
    logic [3:0]   cfg_op = '0;
    logic [1:0]   cfg_src_a = '0;
    logic [1:0]   cfg_src_b = '0;
    logic         cfg_err;
    logic [127:0] lane_res;

    int checks = 0;
    int errors = 0;
    logic [127:0] saved;

    always #5 clk = ~clk;

    cascade_alu_pipe uut (
        .clk(clk), .rst(rst), .issue_valid(issue_valid), .ctx_sel(ctx_sel),
        .rf_raddr(rf_raddr), .wb_en(wb_en), .wb_lane(wb_lane), .wb_addr(wb_addr),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data), .cfg_we(cfg_we),
        .cfg_lane(cfg_lane), .cfg_slot(cfg_slot), .cfg_op(cfg_op),
        .cfg_src_a(cfg_src_a), .cfg_src_b(cfg_src_b), .cfg_err(cfg_err),
        .lane_res(lane_res)
    );

    // opcode, operand A, operand B, expected
    localparam logic [99:0] VEC [10] = '{
        {4'd0, 32'h0000_0005, 32'h0000_0003, 32'h0000_0008},
        {4'd1, 32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE},
        {4'd2, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},
        {4'd3, 32'hF0F0_F0F0, 32'h0F00_000F, 32'hFFF0_F0FF},
        {4'd4, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},
        {4'd5, 32'h0000_0001, 32'h0000_0024, 32'h0000_0010},
        {4'd6, 32'h8000_0000, 32'h0000_001F, 32'h0000_0001},
        {4'd7, 32'h8000_0001, 32'h0000_0004, 32'h0000_0018},
        {4'd8, 32'h1234_5678, 32'hDEAD_BEEF, 32'h1234_5678},
        {4'd15, 32'h1234_5678, 32'h0000_0001, 32'h0000_0000}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        issue_valid = 1'b0; wb_en = 1'b0; ld_en = 1'b0; cfg_we = 1'b0;
    endtask

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_lane(int l, logic [1:0] sel, logic [3:0] ra);
        ctx_sel[l*2 +: 2]  = sel;
        rf_raddr[l*4 +: 4] = ra;
    endtask

    task automatic cfg(logic [1:0] ln, logic [1:0] sl, logic [3:0] op, logic [1:0] sa, logic [1:0] sb);
        cfg_we = 1'b1; cfg_lane = ln; cfg_slot = sl;
        cfg_op = op; cfg_src_a = sa; cfg_src_b = sb;
    endtask

    task automatic load(logic [3:0] a, logic [31:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
    endtask

    function automatic logic [31:0] lane(int l);
        return lane_res[l*32 +: 32];
    endfunction

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        check("R1 results cleared", lane_res, '0);
        check("R1 flag cleared", {127'd0, cfg_err}, '0);

        // R1: default contexts pass the register operand; file cleared
        load(4'd3, 32'h0000_ABCD); tick(); quiet();
        for (int l = 0; l < 3; l++) set_lane(l, 2'd0, 4'd3);
        set_lane(3, 2'd0, 4'd7);
        issue_valid = 1'b1; tick(); quiet();
        check("R1 default context / cleared file",
              lane_res, {32'h0, 32'h0000_ABCD, 32'h0000_ABCD, 32'h0000_ABCD});

        // R2 and R3: opcode table on lane 0, A from self, B from register
        for (int i = 0; i < 10; i++) begin
            load(4'd1, VEC[i][95:64]); tick();
            load(4'd2, VEC[i][63:32]); tick(); quiet();
            cfg(2'd0, 2'd1, VEC[i][99:96], 2'd0, 2'd2); tick(); quiet();
            set_lane(0, 2'd0, 4'd1); issue_valid = 1'b1; tick();
            set_lane(0, 2'd1, 4'd2); tick(); quiet();
            check($sformatf("R2 opcode %0d", VEC[i][99:96]), {96'd0, lane(0)}, {96'd0, VEC[i][31:0]});
        end

        // R3/R4/R6: chain through previous-lane source; background write
        load(4'd4, 32'h5555_AAAA);
        cfg(2'd0, 2'd2, 4'd8, 2'd1, 2'd3); tick(); quiet();
        cfg(2'd1, 2'd2, 4'd8, 2'd1, 2'd3);
        set_lane(0, 2'd0, 4'd4); set_lane(1, 2'd0, 4'd3);
        issue_valid = 1'b1; tick(); quiet();
        check("R6 no flag for write to idle slot", {127'd0, cfg_err}, '0);
        set_lane(0, 2'd2, 4'd0); set_lane(1, 2'd2, 4'd0);
        issue_valid = 1'b1; tick(); quiet();
        check("R4 lane1 gets lane0 prior result", {96'd0, lane(1)}, {96'd0, 32'h5555_AAAA});
        check("R3 lane0 previous source is zero", {96'd0, lane(0)}, '0);

        // R5: hold when not issued
        saved = lane_res;
        set_lane(0, 2'd1, 4'd4); set_lane(1, 2'd1, 4'd4);
        tick();
        check("R5 results hold while idle", lane_res, saved);

        // R7: write to the slot in use this cycle is refused
        set_lane(0, 2'd3, 4'd4);
        cfg(2'd0, 2'd3, 4'd8, 2'd3, 2'd3);
        issue_valid = 1'b1; tick(); quiet();
        check("R7 flag after clash", {127'd0, cfg_err}, {127'd0, 1'b1});
        check("R5 lane0 ran selected slot", {96'd0, lane(0)}, {96'd0, 32'h5555_AAAA});
        set_lane(0, 2'd3, 4'd3); issue_valid = 1'b1; tick(); quiet();
        check("R7 old context kept", {96'd0, lane(0)}, {96'd0, 32'h0000_ABCD});
        check("R7 flag lasts one cycle", {127'd0, cfg_err}, '0);

        // R6: same slot while idle is accepted
        cfg(2'd0, 2'd3, 4'd8, 2'd3, 2'd3); tick(); quiet();
        check("R6 no flag when idle", {127'd0, cfg_err}, '0);
        issue_valid = 1'b1; tick(); quiet();
        check("R6 new context in effect", {96'd0, lane(0)}, '0);

        // R8/R9: write-back of lane 2 read back in the same cycle
        load(4'd6, 32'h0F0F_1234); tick(); quiet();
        for (int l = 0; l < 4; l++) set_lane(l, 2'd0, 4'd3);
        set_lane(2, 2'd0, 4'd6);
        issue_valid = 1'b1; tick(); quiet();
        wb_en = 1'b1; wb_lane = 2'd2; wb_addr = 4'd9;
        set_lane(3, 2'd0, 4'd9);
        issue_valid = 1'b1; tick(); quiet();
        check("R8 same-cycle write-back read", {96'd0, lane(3)}, {96'd0, 32'h0F0F_1234});

        // R9: write-back beats load on the same register
        wb_en = 1'b1; wb_lane = 2'd0; wb_addr = 4'd10;
        load(4'd10, 32'h0000_0077); tick(); quiet();
        set_lane(3, 2'd0, 4'd10); issue_valid = 1'b1; tick(); quiet();
        check("R9 write-back priority", {96'd0, lane(3)}, {96'd0, 32'h0000_ABCD});

        tick();
        finish_run();
    end

endmodule